// File: doc/BRIEF.md
# Eight-bit arithmetic and logic unit with status flags

This block performs one 8-bit arithmetic or logic operation per accepted request. Each request carries an operation code, the accumulator value and a second operand. The block returns the 8-bit result, which the surrounding datapath writes back into its accumulator, together with an 8-bit status byte. The status byte holds five condition flags: sign, zero, auxiliary (nibble) carry, even parity and carry. The flag state is kept inside the block, so add-with-carry and subtract-with-borrow use the carry left by the previous operation. A chain of these operations adds or subtracts numbers many bytes long.

Requests enter on a valid/ready interface. A transfer happens in a cycle where `in_valid` and `in_ready` are both high, and that transfer is the load strobe for the result and flag registers. The result leaves on a second valid/ready interface. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. The block can therefore take one request per cycle while `out_ready` stays high. When the consumer holds `out_ready` low, the result and flags are frozen and new requests wait.

Top module: `alu8_core`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and both `out_result` and `out_flags` are 0.
- R2: A request is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` equals `!out_valid || out_ready`. After an accept, `out_valid` is 1 in the next cycle. While `out_valid` is 1 and `out_ready` is 0, `out_result` and `out_flags` hold their values.
- R3: Code 0 (add) returns acc + opb, and code 1 (add with carry) returns acc + opb + CY, both modulo 256. CY is set when the unsigned sum exceeds 255.
- R4: Code 2 (subtract) returns acc - opb, and code 3 (subtract with borrow) returns acc - opb - CY, both modulo 256. CY is set as a borrow, meaning the unsigned value taken away exceeds acc.
- R5: For codes 0 to 3, 8 and 9, AC is the carry out of bit 3 of an internal adder. For codes 0 and 1 that adder sums acc, opb and the carry-in. For subtraction it sums acc, the bitwise complement of opb, and 1 (code 2) or the inverse of CY (code 3). Increment adds 1. Decrement adds 8'hFF with no carry-in.
- R6: Every operation that writes flags sets Z when the result is 0, sets S to result bit 7, and sets P when the result has an even number of ones.
- R7: Codes 4, 5 and 6 return acc AND opb, acc OR opb and acc XOR opb. All three clear CY. AND sets AC, and OR and XOR clear it.
- R8: Code 7 returns the bitwise complement of acc and leaves all five flags unchanged.
- R9: Code 8 returns acc + 1 and code 9 returns acc - 1, both modulo 256. Both leave CY unchanged.
- R10: Codes 10 to 15 return acc unchanged and leave all flags unchanged.
- R11: `out_flags` places S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and CY at bit 0. Bits 5, 3 and 1 are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present |
| in_ready | output | 1 | The block can accept a request this cycle |
| in_op | input | 4 | Operation code (see R3 to R10) |
| in_acc | input | 8 | Accumulator operand |
| in_opb | input | 8 | Second operand |
| out_valid | output | 1 | Result and flags are valid |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_result | output | 8 | Result of the last accepted request |
| out_flags | output | 8 | Flag register, layout as in R11 |

## Verification
A corrupted carry bit in the flag register becomes visible at `out_flags` bit 0 one cycle after the next accept that does not rewrite it. The same bad carry appears in `out_result` on the next add-with-carry or subtract-with-borrow. A wrong nibble carry or parity shows on the very next flag-writing operation. A stuck output-valid state shows immediately at `in_ready`, because that port is derived from the output stage's occupancy. The sweeps feed every accumulator value against edge-case second operands under all sixteen codes. This lets the chained carry from each previous operation reach the add-with-carry and subtract-with-borrow codes in both of its values.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_CMA = 4'd7,
    OP_INR = 4'd8,
    OP_DCR = 4'd9
  } alu_op_e;

  localparam int FLAG_W = 8;
  localparam int FLG_CY = 0;
  localparam int FLG_P  = 2;
  localparam int FLG_AC = 4;
  localparam int FLG_Z  = 6;
  localparam int FLG_S  = 7;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         half_c
);
  localparam int NIB = 4;
  localparam int NN  = W / NIB;

  logic [NN:0] c;
  assign c[0] = cin;

  for (genvar g = 0; g < NN; g++) begin : g_nib
    logic [NIB:0] s;
    assign s = {1'b0, a[g*NIB +: NIB]} + {1'b0, b[g*NIB +: NIB]}
             + {{NIB{1'b0}}, c[g]};
    assign sum[g*NIB +: NIB] = s[NIB-1:0];
    assign c[g+1] = s[NIB];
  end

  assign cout   = c[NN];
  assign half_c = c[NN/2];
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  import alu8_pkg::*;

  always_comb begin
    case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      default: y = ~a;
    endcase
  end
endmodule

// File: rtl/alu8_flagpack.sv
module alu8_flagpack #(
  parameter int W = 8
) (
  input  logic [W-1:0]               res,
  input  logic                       cy,
  input  logic                       ac,
  output logic [alu8_pkg::FLAG_W-1:0] flags
);
  import alu8_pkg::*;

  always_comb begin
    flags         = '0;
    flags[FLG_S]  = res[W-1];
    flags[FLG_Z]  = (res == '0);
    flags[FLG_AC] = ac;
    flags[FLG_P]  = ~^res;
    flags[FLG_CY] = cy;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic [DATA_W-1:0] in_acc,
  input  logic [DATA_W-1:0] in_opb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [7:0]        out_flags
);
  import alu8_pkg::*;

  logic [FLAG_W-1:0] flag_q;
  logic [DATA_W-1:0] res_q;
  logic              vld_q;
  logic              accept;
  logic              cy_now;

  assign in_ready = !vld_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign cy_now   = flag_q[FLG_CY];

  // operand steering for the shared adder
  logic [DATA_W-1:0] add_b;
  logic              add_cin;

  always_comb begin
    add_b   = in_opb;
    add_cin = 1'b0;
    case (in_op)
      OP_ADC: add_cin = cy_now;
      OP_SUB: begin add_b = ~in_opb; add_cin = 1'b1;    end
      OP_SBB: begin add_b = ~in_opb; add_cin = !cy_now; end
      OP_INR: begin add_b = '0;      add_cin = 1'b1;    end
      OP_DCR: begin add_b = '1;      add_cin = 1'b0;    end
      default: ;
    endcase
  end

  logic [DATA_W-1:0] sum;
  logic              cout;
  logic              half_c;

  alu8_adder #(.W(DATA_W)) u_add (
    .a      (in_acc),
    .b      (add_b),
    .cin    (add_cin),
    .sum    (sum),
    .cout   (cout),
    .half_c (half_c)
  );

  logic [DATA_W-1:0] lres;

  alu8_logic #(.W(DATA_W)) u_log (
    .op (in_op),
    .a  (in_acc),
    .b  (in_opb),
    .y  (lres)
  );

  // result and flag selection
  logic [DATA_W-1:0] nres;
  logic              ncy;
  logic              nac;
  logic              wr_flags;

  always_comb begin
    nres     = in_acc;
    ncy      = cy_now;
    nac      = 1'b0;
    wr_flags = 1'b0;
    case (in_op)
      OP_ADD, OP_ADC: begin
        nres = sum; ncy = cout; nac = half_c; wr_flags = 1'b1;
      end
      OP_SUB, OP_SBB: begin
        nres = sum; ncy = !cout; nac = half_c; wr_flags = 1'b1;
      end
      OP_AND: begin
        nres = lres; ncy = 1'b0; nac = 1'b1; wr_flags = 1'b1;
      end
      OP_OR, OP_XOR: begin
        nres = lres; ncy = 1'b0; nac = 1'b0; wr_flags = 1'b1;
      end
      OP_CMA: begin
        nres = lres;
      end
      OP_INR, OP_DCR: begin
        nres = sum; ncy = cy_now; nac = half_c; wr_flags = 1'b1;
      end
      default: ;
    endcase
  end

  logic [FLAG_W-1:0] nflags;

  alu8_flagpack #(.W(DATA_W)) u_fp (
    .res   (nres),
    .cy    (ncy),
    .ac    (nac),
    .flags (nflags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      flag_q <= '0;
      vld_q  <= 1'b0;
    end else if (accept) begin
      res_q <= nres;
      vld_q <= 1'b1;
      if (wr_flags) flag_q <= nflags;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_flags  = flag_q;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [7:0]        out_flags
);
  logic take;
  logic flag_op;
  assign take    = in_valid && in_ready;
  assign flag_op = take && (in_op <= 4'd6 || in_op == 4'd8 || in_op == 4'd9);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_flags)));

  a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  a_r2_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
    flag_op |=> (out_flags[6] == (out_result == '0)));

  a_r6_sign: assert property (@(posedge clk) disable iff (!rst_n)
    flag_op |=> (out_flags[7] == out_result[DATA_W-1]));

  a_r6_parity: assert property (@(posedge clk) disable iff (!rst_n)
    flag_op |=> (out_flags[2] == ~^out_result));

  a_r7_logic_clears_cy: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op >= 4'd4 && in_op <= 4'd6) |=> !out_flags[0]);

  a_r8_cma_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op == 4'd7) |=> $stable(out_flags));

  a_r9_incdec_keeps_cy: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (in_op == 4'd8 || in_op == 4'd9)) |=> $stable(out_flags[0]));

  a_r10_undefined_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_op >= 4'd10) |=> $stable(out_flags));
endmodule

bind alu8_core alu8_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flags  (out_flags)
);

// File: tb/sim_alu8_core.sv
module sim_alu8_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_op = '0;
  logic [7:0] in_acc = '0;
  logic [7:0] in_opb = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [7:0] out_flags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] mflags = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core #(.DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_acc(in_acc), .in_opb(in_opb), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_flags(out_flags)
  );

  // reference model: returns {flags, result}
  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] f);
    int r;
    int ci;
    logic [7:0] res;
    logic cy, ac, wr;
    res = a; cy = f[0]; ac = 1'b0; wr = 1'b1;
    case (op)
      4'd0, 4'd1: begin
        ci  = (op == 4'd1) ? int'(f[0]) : 0;
        r   = int'(a) + int'(b) + ci;
        res = r[7:0]; cy = (r > 255);
        ac  = (int'(a & 8'h0F) + int'(b & 8'h0F) + ci) > 15;
      end
      4'd2, 4'd3: begin
        ci  = (op == 4'd3) ? int'(f[0]) : 0;
        r   = int'(a) - int'(b) - ci;
        res = r[7:0]; cy = (r < 0);
        ac  = (int'(a & 8'h0F) + int'(~b & 8'h0F) + (1 - ci)) > 15;
      end
      4'd4: begin res = a & b; cy = 1'b0; ac = 1'b1; end
      4'd5: begin res = a | b; cy = 1'b0; ac = 1'b0; end
      4'd6: begin res = a ^ b; cy = 1'b0; ac = 1'b0; end
      4'd7: begin res = ~a; wr = 1'b0; end
      4'd8: begin res = a + 8'd1; ac = (a[3:0] == 4'hF); end
      4'd9: begin res = a - 8'd1; ac = (a[3:0] != 4'h0); end
      default: begin res = a; wr = 1'b0; end
    endcase
    if (wr) return {res[7], (res == 8'h00), 1'b0, ac, 1'b0, ~^res, 1'b0, cy, res};
    else    return {f, res};
  endfunction

  function automatic string res_tag(input logic [3:0] op);
    if (op <= 4'd1) return "R3 add";
    if (op <= 4'd3) return "R4 sub";
    if (op <= 4'd6) return "R7 logic";
    if (op == 4'd7) return "R8 complement";
    if (op <= 4'd9) return "R9 inc/dec";
    return "R10 undefined code";
  endfunction

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    logic [15:0] m;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_acc = a; in_opb = b;
    m = model(op, a, b, mflags);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    mflags = m[15:8];
    check8("R2 out_valid after accept", {7'd0, out_valid}, 8'd1);
    check8(res_tag(op), out_result, m[7:0]);
    if (op == 4'd7)       check8("R8 flags unchanged", out_flags, m[15:8]);
    else if (op >= 4'd10) check8("R10 flags unchanged", out_flags, m[15:8]);
    else if (op >= 4'd8)  check8("R9 R5 R6 flags, CY kept", out_flags, m[15:8]);
    else                  check8("R5 R6 flags", out_flags, m[15:8]);
    check8("R11 unused flag bits", out_flags & 8'h2A, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] bv [8];
    logic [15:0] m;
    bv = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFE, 8'hFF};

    // R1 reset state
    repeat (3) @(negedge clk);
    check8("R1 out_valid", {7'd0, out_valid}, 8'd0);
    check8("R1 in_ready", {7'd0, in_ready}, 8'd1);
    check8("R1 out_result", out_result, 8'h00);
    check8("R1 out_flags", out_flags, 8'h00);
    rst_n = 1'b1;

    // R3 chained add: 0xFF + 0x01 sets CY, then 0+0+CY gives 1
    do_op(4'd0, 8'hFF, 8'h01);
    check8("R3 carry out", {7'd0, out_flags[0]}, 8'd1);
    do_op(4'd1, 8'h00, 8'h00);
    check8("R3 carry chained", out_result, 8'h01);
    // R4 borrow: 0 - 1 sets CY, then 5-2-CY = 2
    do_op(4'd2, 8'h00, 8'h01);
    check8("R4 borrow set", {7'd0, out_flags[0]}, 8'd1);
    do_op(4'd3, 8'h05, 8'h02);
    check8("R4 borrow chained", out_result, 8'h02);

    // R2 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 4'd0; in_acc = 8'h03; in_opb = 8'h04;
    m = model(4'd0, 8'h03, 8'h04, mflags);
    mflags = m[15:8];
    @(posedge clk);
    @(negedge clk);
    check8("R2 valid under stall", {7'd0, out_valid}, 8'd1);
    check8("R2 not ready under stall", {7'd0, in_ready}, 8'd0);
    check8("R2 first result", out_result, 8'h07);
    in_acc = 8'h0A; in_opb = 8'h0A;
    @(posedge clk);
    @(negedge clk);
    check8("R2 result held", out_result, 8'h07);
    check8("R2 flags held", out_flags, mflags);
    out_ready = 1'b1;
    m = model(4'd0, 8'h0A, 8'h0A, mflags);
    mflags = m[15:8];
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check8("R2 queued request taken", out_result, 8'h14);
    @(posedge clk);
    @(negedge clk);
    check8("R2 valid drops after consume", {7'd0, out_valid}, 8'd0);

    // sweep: every code, every accumulator, edge second operands
    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 8; k++)
          do_op(op[3:0], a[7:0], bv[k]);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule